// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Protector

This block guards a data word of `K` bits with an extended Hamming code. The encoder half turns the word into a codeword of `N+1` bits. `N = K + M` Hamming positions carry the check and data bits, and one extra bit holds the parity of the whole word. The decoder half takes a codeword that may have been corrupted on its way through storage or a link. It returns the repaired data word and raises one of two flags. The first flag reports that a single error was repaired. The second reports that two errors were found, which cannot be repaired.

Both halves are purely combinational and share one syndrome network, which is instantiated once in each half. The block is therefore not a stream stage. It has no valid/ready pair and no back-pressure. Results follow the inputs in the same cycle, and the caller registers them wherever its own pipeline needs. An enable input on the decoder switches checking off. When it is low, the data bits are taken from the codeword as received and both flags stay low.

Top module: `secded_pair`

## Requirements
- R1: `M` is the smallest integer with `2**M >= K + M + 1`, and the codeword is `N+1 = K+M+1` bits wide. For the default `K = 15` this gives `M = 5` and a 21-bit codeword.
- R2: Codeword bit `p` for `p` in 1..N is Hamming position `p`. Check bits sit at the positions that are powers of two (1, 2, 4, 8, 16). The data bits fill the other positions in rising order, so data bit 0 is at codeword bit 3 and data bit 14 is at bit 20.
- R3: The check bit at position `2**i` is the XOR of the data bits at every position in 1..N whose index has bit `i` set.
- R4: Codeword bit 0 makes the XOR of all `N+1` codeword bits equal to zero.
- R5: With `en` high and an unaltered codeword, the decoder returns the encoded data and both flags are 0.
- R6: With `en` high and exactly one bit flipped in positions 1..N, the decoder returns the encoded data, `fixed` is 1 and `double` is 0.
- R7: With `en` high and only codeword bit 0 flipped, the data is returned unchanged, `fixed` is 1 and `double` is 0.
- R8: With `en` high and exactly two distinct bits flipped in positions 1..N, `fixed` is 0 and `double` is 1.
- R9: With `en` low, both flags are 0 and each data bit is copied, uncorrected, from its codeword position as given in R2.
- R10: `fixed` and `double` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | K | Data word to protect |
| enc_code_o | output | N+1 | Encoded word; bit 0 is overall parity, bit p is Hamming position p |
| dec_code_i | input | N+1 | Received codeword, possibly corrupted |
| dec_en_i | input | 1 | Enables correction and flagging |
| dec_data_o | output | K | Recovered data word |
| dec_fixed_o | output | 1 | A single error was corrected (or the parity bit alone was hit) |
| dec_double_o | output | 1 | A double error was detected; data not reliable |

## Verification
Correction and double-error detection are both judged from the same syndrome and parity sum in the same evaluation. The bench flips one bit and then two bits of the same encoded word. It requires the corrected-data path and the flag pair to agree each time: the data is restored together with `fixed` alone, or `double` is raised alone. The enable gate and a live error also land together. The bench applies a single flip with `dec_en_i` low and expects the corrupted bit to appear in the data while both flags stay quiet.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // smallest check-bit count meeting the Hamming bound for k data bits
  function automatic int calc_m(input int k);
    int m;
    m = 1;
    while ((1 << m) < k + m + 1) m++;
    return m;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Hamming position holding data bit j (non-power-of-two slots, ascending)
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    bit found;
    cnt   = 0;
    res   = 0;
    found = 1'b0;
    for (int p = 1; p < 4096; p++) begin
      if (!found && !is_pow2(p)) begin
        if (cnt == j) begin
          res   = p;
          found = 1'b1;
        end
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int N = 20,
  parameter int M = 5
) (
  input  logic [N:1]   pos_i,
  output logic [M-1:0] syn_o
);
  // bit i = XOR of every position whose index has bit i set
  always_comb begin
    for (int i = 0; i < M; i++) begin
      syn_o[i] = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> i) & 1) == 1) syn_o[i] = syn_o[i] ^ pos_i[p];
      end
    end
  end
endmodule

// File: rtl/secded_encoder.sv
module secded_encoder #(
  parameter int K = 15,
  parameter int M = 5,
  parameter int N = 20
) (
  input  logic [K-1:0] data_i,
  output logic [N:0]   code_o
);
  logic [N:1]   raw;
  logic [N:1]   full;
  logic [M-1:0] chk;

  for (genvar j = 0; j < K; j++) begin : g_data
    localparam int DP = secded_pkg::data_pos(j);
    assign raw[DP]  = data_i[j];
    assign full[DP] = data_i[j];
  end

  for (genvar i = 0; i < M; i++) begin : g_chk
    localparam int CP = 1 << i;
    assign raw[CP]  = 1'b0;
    assign full[CP] = chk[i];
  end

  secded_syndrome #(.N(N), .M(M)) u_syn (
    .pos_i (raw),
    .syn_o (chk)
  );

  assign code_o = {full, ^full};
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder #(
  parameter int K = 15,
  parameter int M = 5,
  parameter int N = 20
) (
  input  logic [N:0]   code_i,
  input  logic         en_i,
  output logic [K-1:0] data_o,
  output logic         fixed_o,
  output logic         double_o
);
  logic [M-1:0] syn;
  logic         par_err;
  logic [N:1]   flip_mask;
  logic [N:1]   repaired;

  secded_syndrome #(.N(N), .M(M)) u_syn (
    .pos_i (code_i[N:1]),
    .syn_o (syn)
  );

  assign par_err = ^code_i;

  always_comb begin
    flip_mask = '0;
    if (en_i && par_err && (syn != '0) && (int'(syn) <= N))
      flip_mask[int'(syn)] = 1'b1;
  end

  assign repaired = code_i[N:1] ^ flip_mask;
  assign fixed_o  = en_i & par_err;
  assign double_o = en_i & ~par_err & (syn != '0);

  for (genvar j = 0; j < K; j++) begin : g_out
    localparam int DP = secded_pkg::data_pos(j);
    assign data_o[j] = repaired[DP];
  end
endmodule

// File: rtl/secded_pair.sv
module secded_pair #(
  parameter int K = 15,
  localparam int M = secded_pkg::calc_m(K),
  localparam int N = K + M
) (
  input  logic [K-1:0] enc_data_i,
  output logic [N:0]   enc_code_o,
  input  logic [N:0]   dec_code_i,
  input  logic         dec_en_i,
  output logic [K-1:0] dec_data_o,
  output logic         dec_fixed_o,
  output logic         dec_double_o
);
  secded_encoder #(.K(K), .M(M), .N(N)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_decoder #(.K(K), .M(M), .N(N)) u_dec (
    .code_i   (dec_code_i),
    .en_i     (dec_en_i),
    .data_o   (dec_data_o),
    .fixed_o  (dec_fixed_o),
    .double_o (dec_double_o)
  );
endmodule

// File: rtl/secded_checker.sv
module secded_checker #(
  parameter int K = 15,
  parameter int N = 20
) (
  input logic [K-1:0] enc_data_i,
  input logic [N:0]   enc_code_o,
  input logic [N:0]   dec_code_i,
  input logic         dec_en_i,
  input logic [K-1:0] dec_data_o,
  input logic         dec_fixed_o,
  input logic         dec_double_o
);
  always_comb begin
    a_r10_flags_exclusive: assert (!(dec_fixed_o && dec_double_o));
    a_r9_disabled_quiet: assert (dec_en_i || (!dec_fixed_o && !dec_double_o));
    a_r4_even_parity: assert ((^enc_code_o) == 1'b0);
    a_r2_bit0_slot: assert (enc_code_o[3] == enc_data_i[0]);
    a_r5_clean_roundtrip: assert (!(dec_en_i && dec_code_i == enc_code_o)
                                  || (dec_data_o == enc_data_i && !dec_fixed_o && !dec_double_o));
  end
endmodule

bind secded_pair secded_checker #(.K(K), .N(N)) u_secded_chk (
  .enc_data_i   (enc_data_i),
  .enc_code_o   (enc_code_o),
  .dec_code_i   (dec_code_i),
  .dec_en_i     (dec_en_i),
  .dec_data_o   (dec_data_o),
  .dec_fixed_o  (dec_fixed_o),
  .dec_double_o (dec_double_o)
);

// File: tb/test_secded_pair.sv
module test_secded_pair;
  localparam int PERIOD = 10;
  localparam int K = 15;
  localparam int N = 20;

  logic         clk = 1'b0;
  logic [K-1:0] enc_data;
  logic [N:0]   enc_code;
  logic [N:0]   flip;
  logic [N:0]   dec_code;
  logic         dec_en;
  logic [K-1:0] dec_data;
  logic         fixed_f;
  logic         double_f;
  int           n_chk = 0;
  int           n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  assign dec_code = enc_code ^ flip;

  secded_pair #(.K(K)) i_secded_pair (
    .enc_data_i   (enc_data),
    .enc_code_o   (enc_code),
    .dec_code_i   (dec_code),
    .dec_en_i     (dec_en),
    .dec_data_o   (dec_data),
    .dec_fixed_o  (fixed_f),
    .dec_double_o (double_f)
  );

  function automatic bit b_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  function automatic int b_dpos(input int j);
    int c;
    int r;
    c = 0;
    r = 0;
    for (int p = 1; p <= N; p++) begin
      if (!b_pow2(p)) begin
        if (c == j) r = p;
        c++;
      end
    end
    return r;
  endfunction

  function automatic logic [N:0] b_encode(input logic [K-1:0] d);
    logic [N:0] c;
    c = '0;
    for (int j = 0; j < K; j++) c[b_dpos(j)] = d[j];
    for (int i = 0; i < 5; i++) begin
      logic s;
      s = 1'b0;
      for (int p = 1; p <= N; p++)
        if (!b_pow2(p) && ((p >> i) & 1) == 1) s = s ^ c[p];
      c[1 << i] = s;
    end
    c[0] = ^c[N:1];
    return c;
  endfunction

  function automatic logic [K-1:0] b_extract(input logic [N:0] c);
    logic [K-1:0] d;
    for (int j = 0; j < K; j++) d[j] = c[b_dpos(j)];
    return d;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [K-1:0] d, input logic [N:0] f, input logic en);
    @(negedge clk);
    enc_data = d;
    flip     = f;
    dec_en   = en;
    #1;
  endtask

  task automatic t_layout(input logic [K-1:0] d);
    apply(d, '0, 1'b1);
    cmp("R1 width", $bits(enc_code), 21);
    cmp("R2/R3 codeword", 32'(enc_code), 32'(b_encode(d)));
    cmp("R2 bit0 at pos3", 32'(enc_code[3]), 32'(d[0]));
    cmp("R4 overall parity", 32'(^enc_code), 0);
  endtask

  task automatic t_clean(input logic [K-1:0] d);
    apply(d, '0, 1'b1);
    cmp("R5 data", 32'(dec_data), 32'(d));
    cmp("R5 flags", {30'd0, fixed_f, double_f}, 0);
  endtask

  task automatic t_single(input logic [K-1:0] d, input int p);
    apply(d, (N+1)'(1) << p, 1'b1);
    if (p == 0) begin
      cmp("R7 data", 32'(dec_data), 32'(d));
      cmp("R7 flags", {30'd0, fixed_f, double_f}, 2);
    end else begin
      cmp("R6 data", 32'(dec_data), 32'(d));
      cmp("R6 flags", {30'd0, fixed_f, double_f}, 2);
    end
  endtask

  task automatic t_double(input logic [K-1:0] d, input int p1, input int p2);
    apply(d, ((N+1)'(1) << p1) | ((N+1)'(1) << p2), 1'b1);
    cmp("R8 flags", {30'd0, fixed_f, double_f}, 1);
    cmp("R10 exclusive", 32'(fixed_f & double_f), 0);
  endtask

  task automatic t_disabled(input logic [K-1:0] d, input int p);
    logic [N:0] f;
    f = (N+1)'(1) << p;
    apply(d, f, 1'b0);
    cmp("R9 raw data", 32'(dec_data), 32'(b_extract(b_encode(d) ^ f)));
    cmp("R9 flags", {30'd0, fixed_f, double_f}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [K-1:0] pats [6];
    pats[0] = 15'h0000; pats[1] = 15'h7FFF; pats[2] = 15'h5555;
    pats[3] = 15'h2AAA; pats[4] = 15'h0001; pats[5] = 15'h4C3B;
    enc_data = '0;
    flip     = '0;
    dec_en   = 1'b1;
    repeat (2) @(posedge clk);
    for (int a = 0; a < 6; a++) begin
      t_layout(pats[a]);
      t_clean(pats[a]);
      for (int p = 0; p <= N; p++) t_single(pats[a], p);
      for (int p = 1; p <= N; p++) t_disabled(pats[a], p);
    end
    for (int a = 0; a < 3; a++)
      for (int p1 = 1; p1 <= N; p1++)
        for (int p2 = p1 + 1; p2 <= N; p2++) t_double(pats[a], p1, p2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule